// File: doc/BRIEF.md
# ADC result window comparator

This block watches the stream of finished converter results and raises a sticky detection flag when a result satisfies a programmed window condition. Two limit words are held: an upper-crossing limit (the result must be strictly above it) and a lower-crossing limit (the result must be strictly below it). Each limit is written and read as a low byte and a high byte through a byte-wide register port addressed by a small register select. The flag can be polled through a control register and, when the interrupt enable is set, drives the interrupt output. Software clears it by writing zero to the flag bit.

There is no mode bit. The order of the two limits selects the mode. If the upper-crossing limit is below the lower-crossing limit, the flag marks a result inside the open window between them. Otherwise it marks a result outside the window. After reset the upper-crossing limit is all ones and the lower-crossing limit is zero, so no result can set the flag.

The flag is a two-state machine. ARMED moves to TRIPPED (transition HIT) when a result strobe arrives with a qualifying result. TRIPPED moves back to ARMED (transition CLEAR) when software writes zero to the flag bit and no qualifying result arrives in the same cycle. In every other case the state stays where it is (transitions IDLE and HOLD).

Top module: `adc_window_watch`

## Requirements
- R1: Register selects 0, 1, 2 and 3 address the upper-crossing limit low byte, its high byte, the lower-crossing limit low byte and its high byte. Each is written by `wr_en` with `wr_data` and is read back on `rd_data` while selected.
- R2: After reset, both upper-crossing limit bytes read all ones, both lower-crossing limit bytes read zero, and the control register reads zero. With these limits no result sets the flag.
- R3: When the upper-crossing limit is below the lower-crossing limit, a strobed result sets the flag exactly when it is strictly above the upper-crossing limit and strictly below the lower-crossing limit.
- R4: When the upper-crossing limit is at or above the lower-crossing limit, a strobed result sets the flag exactly when it is strictly below the lower-crossing limit or strictly above the upper-crossing limit.
- R5: A result is compared only in a cycle where `sample_valid` is high. A qualifying value present without the strobe leaves the flag unchanged.
- R6: The flag is bit 0 of the control register (select 4) and stays set until a control write with bit 0 equal to zero. A control write with bit 0 equal to one neither sets nor clears it.
- R7: If a qualifying strobed result and a clearing control write fall in the same cycle, the flag ends up set.
- R8: Bit 1 of the control register is the interrupt enable. `irq` is high exactly when both the flag and the enable are set.
- R9: A limit byte write takes effect from the next cycle. A result strobed in the same cycle as the write is compared against the old limit.
- R10: Selects 5 to 7 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 3 | Register select for reads and writes |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | BYTE_W | Write data |
| rd_data | output | BYTE_W | Read data of the selected register (combinational) |
| sample_valid | input | 1 | One-cycle strobe marking a finished result |
| sample | input | 2*BYTE_W | Converter result |
| irq | output | 1 | Window interrupt request |

## Verification
The bench uses a small configuration with 8-bit results. For each of several limit pairs it sweeps every possible result value: a normal inside window, a normal outside window, equal limits, the widest inside window, an empty inside window (adjacent limits) and the reset-like pair. These patterns separate the strict comparisons from non-strict ones and expose a wrong mode choice at the equality boundary. Directed sequences then check that a value present without the strobe is ignored, how a clear and a qualifying result interact in the same cycle, that a write-one to the flag bit has no effect, and that a limit write in the same cycle as a result leaves the old limit in use for that result.

// File: rtl/adcw_pkg.sv
package adcw_pkg;

    typedef enum logic {
        FLAG_ARMED   = 1'b0,
        FLAG_TRIPPED = 1'b1
    } flag_state_t;

    localparam logic [2:0] SEL_UP_LO  = 3'd0;
    localparam logic [2:0] SEL_UP_HI  = 3'd1;
    localparam logic [2:0] SEL_DN_LO  = 3'd2;
    localparam logic [2:0] SEL_DN_HI  = 3'd3;
    localparam logic [2:0] SEL_CTRL   = 3'd4;

    localparam int CTRL_FLAG_BIT = 0;
    localparam int CTRL_IEN_BIT  = 1;

endpackage

// File: rtl/adcw_limit_reg.sv
module adcw_limit_reg #(
    parameter int BYTE_W     = 8,
    parameter bit RESET_ONES = 1'b0,
    localparam int DATA_W    = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_lo,
    input  logic              we_hi,
    input  logic [BYTE_W-1:0] wdata,
    output logic [DATA_W-1:0] limit
);

    localparam logic [BYTE_W-1:0] RST_BYTE = RESET_ONES ? {BYTE_W{1'b1}} : {BYTE_W{1'b0}};

    logic [BYTE_W-1:0] lo_q;
    logic [BYTE_W-1:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= RST_BYTE;
            hi_q <= RST_BYTE;
        end else begin
            if (we_lo) lo_q <= wdata;
            if (we_hi) hi_q <= wdata;
        end
    end

    assign limit = {hi_q, lo_q};

    // R1 / R9: a byte write lands in the following cycle, the other byte is kept
    p_lo_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        we_lo && !we_hi |=> (limit[BYTE_W-1:0] == $past(wdata)) && $stable(limit[DATA_W-1:BYTE_W]));
    p_hi_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        we_hi && !we_lo |=> (limit[DATA_W-1:BYTE_W] == $past(wdata)) && $stable(limit[BYTE_W-1:0]));
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !we_lo && !we_hi |=> $stable(limit));

endmodule

// File: rtl/adcw_compare.sv
module adcw_compare #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] sample,
    input  logic [DATA_W-1:0] up_lim,
    input  logic [DATA_W-1:0] dn_lim,
    output logic              hit
);

    logic inside_mode;
    logic above_up;
    logic below_dn;

    always_comb begin
        inside_mode = (up_lim < dn_lim);
        above_up    = (sample > up_lim);
        below_dn    = (sample < dn_lim);
        if (inside_mode) begin
            hit = above_up && below_dn;
        end else begin
            hit = above_up || below_dn;
        end
    end

    // R2: the reset limit pair can never produce a hit
    always_comb begin
        if (up_lim == {DATA_W{1'b1}} && dn_lim == {DATA_W{1'b0}}) begin
            p_no_trip_at_reset_r2: assert (!hit);
        end
    end

endmodule

// File: rtl/adcw_flag_fsm.sv
module adcw_flag_fsm
    import adcw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic eval,
    input  logic hit,
    input  logic clr_req,
    output logic flag
);

    flag_state_t state_q;
    flag_state_t state_d;
    logic        set_now;

    assign set_now = eval && hit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_ARMED: begin
                if (set_now) state_d = FLAG_TRIPPED;   // HIT
                else         state_d = FLAG_ARMED;     // IDLE
            end
            FLAG_TRIPPED: begin
                if (clr_req && !set_now) state_d = FLAG_ARMED;   // CLEAR
                else                     state_d = FLAG_TRIPPED; // HOLD
            end
            default: state_d = FLAG_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        flag = (state_q == FLAG_TRIPPED);
    end

    p_set_on_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eval && hit |=> flag);
    p_no_set_without_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !flag && !eval |=> !flag);
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !clr_req |=> flag);
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flag && clr_req && !(eval && hit) |=> !flag);

endmodule

// File: rtl/adc_window_watch.sv
module adc_window_watch
    import adcw_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int DATA_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_sel,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              sample_valid,
    input  logic [DATA_W-1:0] sample,
    output logic              irq
);

    localparam int NUM_LIM = 2;

    logic [NUM_LIM-1:0][DATA_W-1:0] lim;
    logic hit;
    logic flag;
    logic ien_q;
    logic ctrl_wr;
    logic clr_req;

    assign ctrl_wr = wr_en && (reg_sel == SEL_CTRL);
    assign clr_req = ctrl_wr && !wr_data[CTRL_FLAG_BIT];

    // limit 0: upper-crossing (resets to ones), limit 1: lower-crossing (resets to zero)
    for (genvar g = 0; g < NUM_LIM; g++) begin : g_lim
        localparam logic [2:0] SEL_LO = 3'(2 * g);
        localparam logic [2:0] SEL_HI = 3'(2 * g + 1);
        adcw_limit_reg #(
            .BYTE_W     (BYTE_W),
            .RESET_ONES (g == 0)
        ) u_lim (
            .clk   (clk),
            .rst_n (rst_n),
            .we_lo (wr_en && (reg_sel == SEL_LO)),
            .we_hi (wr_en && (reg_sel == SEL_HI)),
            .wdata (wr_data),
            .limit (lim[g])
        );
    end

    adcw_compare #(.DATA_W(DATA_W)) u_cmp (
        .sample (sample),
        .up_lim (lim[0]),
        .dn_lim (lim[1]),
        .hit    (hit)
    );

    adcw_flag_fsm u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .eval    (sample_valid),
        .hit     (hit),
        .clr_req (clr_req),
        .flag    (flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ien_q <= 1'b0;
        else if (ctrl_wr) ien_q <= wr_data[CTRL_IEN_BIT];
    end

    always_comb begin
        rd_data = '0;
        case (reg_sel)
            SEL_UP_LO: rd_data = lim[0][BYTE_W-1:0];
            SEL_UP_HI: rd_data = lim[0][DATA_W-1:BYTE_W];
            SEL_DN_LO: rd_data = lim[1][BYTE_W-1:0];
            SEL_DN_HI: rd_data = lim[1][DATA_W-1:BYTE_W];
            SEL_CTRL: begin
                rd_data[CTRL_FLAG_BIT] = flag;
                rd_data[CTRL_IEN_BIT]  = ien_q;
            end
            default: rd_data = '0;
        endcase
    end

    assign irq = flag && ien_q;

    p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_q |-> !irq);
    p_write_one_keeps_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flag && ctrl_wr && wr_data[CTRL_FLAG_BIT] |=> flag);
    p_unused_sel_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel > SEL_CTRL |-> rd_data == '0);

endmodule

// File: tb/adc_window_watch_bench.sv
`timescale 1ns/1ps
module adc_window_watch_bench;

    localparam int BW = 4;
    localparam int DW = 2 * BW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    reg_sel = '0;
    logic          wr_en = 1'b0;
    logic [BW-1:0] wr_data = '0;
    logic [BW-1:0] rd_data;
    logic          sample_valid = 1'b0;
    logic [DW-1:0] sample = '0;
    logic          irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    adc_window_watch #(.BYTE_W(BW)) u_adc_window_watch (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_sel      (reg_sel),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .sample_valid (sample_valid),
        .sample       (sample),
        .irq          (irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_hit(input int s, input int up, input int dn);
        if (up < dn) return (s > up) && (s < dn);
        return (s < dn) || (s > up);
    endfunction

    task automatic wr(input int sel, input int d);
        @(negedge clk);
        reg_sel = 3'(sel);
        wr_data = BW'(d);
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd(input int sel, output int v);
        reg_sel = 3'(sel);
        #1;
        v = int'(rd_data);
    endtask

    task automatic set_limits(input int up, input int dn);
        wr(0, up & 15);
        wr(1, (up >> 4) & 15);
        wr(2, dn & 15);
        wr(3, (dn >> 4) & 15);
    endtask

    task automatic pulse(input int s);
        @(negedge clk);
        sample       = DW'(s);
        sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic sweep(input string tag, input int up, input int dn);
        set_limits(up, dn);
        wr(4, 2);
        for (int s = 0; s < 256; s++) begin
            pulse(s);
            checks++;
            if (irq !== exp_hit(s, up, dn)) begin
                failures++;
                $display("FAIL %s up=%0h dn=%0h sample=%0h actual=%0b expected=%0b",
                         tag, up, dn, s, irq, exp_hit(s, up, dn));
            end
            if (irq) wr(4, 2);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset values
        rd(0, v); check("R2 up lo reset", v, 15);
        rd(1, v); check("R2 up hi reset", v, 15);
        rd(2, v); check("R2 dn lo reset", v, 0);
        rd(3, v); check("R2 dn hi reset", v, 0);
        rd(4, v); check("R2 ctrl reset", v, 0);
        check("R2 irq reset", int'(irq), 0);

        // R2 no result trips with reset limits (enable set so irq shows flag)
        wr(4, 2);
        for (int s = 0; s < 256; s++) begin
            pulse(s);
            checks++;
            if (irq !== 1'b0) begin
                failures++;
                $display("FAIL R2 reset limits sample=%0h actual=%0b expected=0", s, irq);
            end
        end

        // R1 read back of written bytes
        set_limits(8'h3A, 8'hC5);
        rd(0, v); check("R1 up lo", v, 4'hA);
        rd(1, v); check("R1 up hi", v, 4'h3);
        rd(2, v); check("R1 dn lo", v, 4'h5);
        rd(3, v); check("R1 dn hi", v, 4'hC);

        // R3 inside, R4 outside sweeps
        sweep("R3 inside", 8'h40, 8'hC0);
        sweep("R3 inside widest", 8'h00, 8'hFF);
        sweep("R3 inside empty", 8'h7F, 8'h80);
        sweep("R4 outside", 8'hC0, 8'h40);
        sweep("R4 outside equal", 8'h80, 8'h80);
        sweep("R4 outside reset pair", 8'hFF, 8'h00);

        // R5 qualifying value without strobe
        set_limits(8'h40, 8'hC0);
        wr(4, 2);
        @(negedge clk);
        sample = 8'h80;
        repeat (4) @(negedge clk);
        rd(4, v); check("R5 no strobe flag", v & 1, 0);
        check("R5 no strobe irq", int'(irq), 0);

        // R6 sticky, write-one no effect, write-zero clears
        pulse(8'h80);
        repeat (3) @(negedge clk);
        rd(4, v); check("R6 sticky flag", v & 1, 1);
        wr(4, 3);
        rd(4, v); check("R6 write one keeps flag", v & 1, 1);
        check("R6 irq kept", int'(irq), 1);
        wr(4, 2);
        rd(4, v); check("R6 write zero clears", v & 1, 0);
        wr(4, 3);
        rd(4, v); check("R6 write one does not set", v & 1, 0);

        // R7 set wins over clear in same cycle
        @(negedge clk);
        sample = 8'h80; sample_valid = 1'b1;
        reg_sel = 3'd4; wr_data = 4'h2; wr_en = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0; wr_en = 1'b0;
        rd(4, v); check("R7 set priority", v & 1, 1);
        // clear together with non-qualifying strobe clears
        @(negedge clk);
        sample = 8'h10; sample_valid = 1'b1;
        reg_sel = 3'd4; wr_data = 4'h2; wr_en = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0; wr_en = 1'b0;
        rd(4, v); check("R7 clear with miss", v & 1, 0);

        // R8 irq gated by enable
        wr(4, 0);
        pulse(8'h80);
        check("R8 irq off when disabled", int'(irq), 0);
        rd(4, v); check("R8 flag set while disabled", v, 1);
        wr(4, 3);
        check("R8 irq on after enable", int'(irq), 1);
        wr(4, 2);

        // R9 same-cycle limit write uses old limit (up 0x40 -> 0x50)
        @(negedge clk);
        sample = 8'h41; sample_valid = 1'b1;
        reg_sel = 3'd1; wr_data = 4'h5; wr_en = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0; wr_en = 1'b0;
        check("R9 old limit used", int'(irq), 1);
        wr(4, 2);
        pulse(8'h41);
        check("R9 new limit used", int'(irq), 0);

        // R10 unused selects
        wr(5, 4'hF);
        wr(7, 4'hF);
        rd(5, v); check("R10 sel5 reads zero", v, 0);
        rd(7, v); check("R10 sel7 reads zero", v, 0);
        rd(0, v); check("R10 up lo untouched", v, 0);
        rd(1, v); check("R10 up hi untouched", v, 5);
        rd(2, v); check("R10 dn lo untouched", v, 0);
        rd(3, v); check("R10 dn hi untouched", v, 4'hC);
        rd(4, v); check("R10 ctrl untouched", v, 2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule